// File: doc/BRIEF.md
# Leaky Eligibility Trace Counter

This block keeps a short memory of recent plasticity events for a spike-timing learning engine. Each time the update engine reports a qualifying pre/post spike pair, the block bumps an 8-bit trace and stores the signed-magnitude update that came with the pair. Left alone, the trace leaks away by one count per decay period. The period is a power of two in system-clock cycles and comes from a 4-bit rate field.

A reward that arrives while the trace is still nonzero gets credit. The block releases the most recently stored update one cycle later and wipes the trace, so one reward credits one burst of activity. When the trace has leaked to zero, a late reward does nothing. Curve lookup, learning-rate scaling and register access sit outside this block. The trace value and an eligibility flag are exported so that a status path can read them.

Top module: `elig_trace`

## Requirements
- R1: Out of reset, `trace_o` is 0, `elig_o` is 0, `release_o` is 0 and `release_delta_o` is 0.
- R2: While `trace_en_i` is low, the trace is cleared to 0 at the next clock edge. Pairs and rewards are ignored and `release_o` stays low.
- R3: With trace enabled, a cycle with `pair_i` high and no credit raises the trace by exactly one at the next clock edge.
- R4: The trace saturates at 255. Further pairs leave it at 255.
- R5: With `decay_i` = d, where d is between 1 and 15, the trace drops by one every 2^d clock cycles. The period restarts at each pair, so the first drop comes 2^d edges after the pair's edge. The trace never goes below 0.
- R6: With `decay_i` = 0 the trace never decays.
- R7: A pair arriving in the cycle where a decay step is due raises the trace and suppresses the decay step.
- R8: `elig_o` is high exactly when `trace_o` is nonzero.
- R9: When trace is enabled, `reward_i` is high and the trace is nonzero, the following happens at the next edge: `release_o` pulses high for one cycle, `release_delta_o` takes the delta stored by the most recent earlier pair, and the trace is cleared to 0.
- R10: A reward while the trace is 0 produces no release. `release_delta_o` holds its value whenever `release_o` is low.
- R11: When a reward and a pair coincide on a nonzero trace, the release carries the previously stored delta and the trace clears. The new pair's delta is stored for the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trace_en_i | input | 1 | Trace mode enable |
| pair_i | input | 1 | Qualifying spike-pair strobe, one cycle per pair |
| delta_i | input | 8 | Gated weight update accompanying the pair |
| decay_i | input | 4 | Decay rate d; period is 2^d cycles, 0 disables decay |
| reward_i | input | 1 | Reward input |
| trace_o | output | 8 | Current trace value |
| elig_o | output | 1 | Trace nonzero, reward would be credited |
| release_o | output | 1 | One-cycle pulse when a stored update is released |
| release_delta_o | output | 8 | Released update value, held between releases |

## Verification
Some rules are checked by assertions on every cycle:
- the single-step increment;
- saturation at 255;
- the floor at zero;
- clearing while disabled;
- a release being preceded by a nonzero trace, with the trace cleared in the same cycle;
- the released value being held between releases.

The exact leak timing across decay rates depends on counting from the last pair, so only the bench's sweeps over rate and burst length can show it. The same is true of suppression of a due decay step by a pair, and of which stored delta a coinciding reward and pair release.

// File: rtl/elig_pkg.sv
package elig_pkg;
  localparam int unsigned TRACE_W = 8;
  localparam int unsigned DECAY_W = 4;
  localparam int unsigned DELTA_W = 8;
endpackage

// File: rtl/elig_decay_pre.sv
module elig_decay_pre #(
  parameter int unsigned DECAY_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               restart_i,
  input  logic [DECAY_W-1:0] rate_i,
  output logic               tick_o
);
  localparam int unsigned PRE_W = (1 << DECAY_W) - 1;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;
  logic             at_lim;

  // period 2^rate: count 0 .. 2^rate-1
  assign lim    = (PRE_W'(1) << rate_i) - PRE_W'(1);
  assign at_lim = (cnt_q == lim);
  assign tick_o = en_i && (rate_i != '0) && at_lim && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (!en_i || restart_i || rate_i == '0)  cnt_q <= '0;
    else if (at_lim)                              cnt_q <= '0;
    else                                          cnt_q <= cnt_q + PRE_W'(1);
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim || $changed(rate_i)); // R5
endmodule

// File: rtl/elig_sat_cnt.sv
module elig_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || clr_i)   cnt_q <= '0;
    else if (inc_i) begin
      if (cnt_q != MAX)        cnt_q <= cnt_q + W'(1);
    end
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0); // R2
  AST_INC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && inc_i && cnt_q != MAX |=> cnt_q == $past(cnt_q) + W'(1)); // R3
  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && inc_i && cnt_q == MAX |=> cnt_q == MAX); // R4
  AST_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && !inc_i && cnt_q == '0 |=> cnt_q == '0); // R5
  AST_INC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && inc_i && dec_i |=> cnt_q >= $past(cnt_q)); // R7
endmodule

// File: rtl/elig_credit.sv
module elig_credit #(
  parameter int unsigned DELTA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               reward_i,
  input  logic               trace_nz_i,
  input  logic               pair_i,
  input  logic [DELTA_W-1:0] delta_i,
  output logic               fire_o,
  output logic               release_o,
  output logic [DELTA_W-1:0] release_delta_o
);
  logic [DELTA_W-1:0] store_q;
  logic               rel_q;
  logic [DELTA_W-1:0] rel_delta_q;

  assign fire_o          = en_i && reward_i && trace_nz_i;
  assign release_o       = rel_q;
  assign release_delta_o = rel_delta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q     <= '0;
      rel_q       <= 1'b0;
      rel_delta_q <= '0;
    end else begin
      rel_q <= fire_o;
      if (fire_o)             rel_delta_q <= store_q;  // old value, before this cycle's pair
      if (en_i && pair_i)     store_q     <= delta_i;
    end
  end

  AST_REL_NEEDS_TRACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> $past(trace_nz_i) && $past(reward_i)); // R9
  AST_REL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> !trace_nz_i); // R9
  AST_DELTA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !release_o |-> $stable(release_delta_o)); // R10
endmodule

// File: rtl/elig_trace.sv
module elig_trace
  import elig_pkg::*;
#(
  parameter int unsigned TW = TRACE_W,
  parameter int unsigned DW = DECAY_W,
  parameter int unsigned VW = DELTA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trace_en_i,
  input  logic          pair_i,
  input  logic [VW-1:0] delta_i,
  input  logic [DW-1:0] decay_i,
  input  logic          reward_i,
  output logic [TW-1:0] trace_o,
  output logic          elig_o,
  output logic          release_o,
  output logic [VW-1:0] release_delta_o
);
  logic          tick;
  logic          fire;
  logic [TW-1:0] trace;

  elig_decay_pre #(.DECAY_W(DW)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (trace_en_i),
    .restart_i (pair_i | fire),
    .rate_i    (decay_i),
    .tick_o    (tick)
  );

  elig_sat_cnt #(.W(TW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (trace_en_i),
    .inc_i  (pair_i),
    .dec_i  (tick),
    .clr_i  (fire),
    .cnt_o  (trace)
  );

  elig_credit #(.DELTA_W(VW)) u_credit (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .en_i            (trace_en_i),
    .reward_i        (reward_i),
    .trace_nz_i      (trace != '0),
    .pair_i          (pair_i),
    .delta_i         (delta_i),
    .fire_o          (fire),
    .release_o       (release_o),
    .release_delta_o (release_delta_o)
  );

  assign trace_o = trace;
  assign elig_o  = (trace != '0);

  AST_NO_REL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trace_en_i |=> !release_o); // R2
  AST_ELIG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elig_o == (trace_o != '0)); // R8
endmodule

// File: tb/elig_trace_bench.sv
module elig_trace_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, pair = 1'b0, reward = 1'b0;
  logic [7:0] delta = '0;
  logic [3:0] decay = '0;
  logic [7:0] trace;
  logic       elig, rel;
  logic [7:0] rel_delta;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  elig_trace u_elig_trace (
    .clk_i(clk), .rst_ni(rst_n), .trace_en_i(en), .pair_i(pair), .delta_i(delta),
    .decay_i(decay), .reward_i(reward), .trace_o(trace), .elig_o(elig),
    .release_o(rel), .release_delta_o(rel_delta)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one edge; sample and drive 1ns after it
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic pulse_pair(input logic [7:0] d);
    pair = 1'b1; delta = d; cyc(); pair = 1'b0;
  endtask

  task automatic clear_trace();
    en = 1'b0; cyc(); en = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R1 trace", trace, 0);
    chk("R1 elig", elig, 0);
    chk("R1 release", rel, 0);
    chk("R1 delta", rel_delta, 0);
    cyc(); rst_n = 1'b1; cyc();

    // R2: disabled ignores pairs and rewards
    en = 1'b0; decay = 4'd0;
    pulse_pair(8'h11); pulse_pair(8'h12);
    chk("R2 trace off", trace, 0);
    reward = 1'b1; cyc(); reward = 1'b0;
    chk("R2 no release", rel, 0);
    en = 1'b1; pulse_pair(8'h05); pulse_pair(8'h06);
    chk("R3 two pairs", trace, 2);
    en = 1'b0; cyc();
    chk("R2 clears", trace, 0);
    en = 1'b1;

    // R3/R6: no decay, sweep increment counts
    for (int n = 1; n <= 6; n++) begin
      clear_trace();
      for (int k = 0; k < n; k++) pulse_pair(8'(k));
      chk("R3 count", trace, n);
      chk("R8 elig", elig, 1);
      for (int k = 0; k < 40; k++) cyc();
      chk("R6 no decay", trace, n);
    end

    // R4: saturation
    clear_trace();
    pair = 1'b1; delta = 8'h33;
    for (int k = 0; k < 260; k++) cyc();
    pair = 1'b0;
    chk("R4 saturate", trace, 255);

    // R5: leak timing sweep over rate and burst length
    for (int d = 1; d <= 4; d++) begin
      for (int n = 1; n <= 3; n++) begin
        clear_trace();
        decay = 4'(d);
        for (int k = 0; k < n; k++) pulse_pair(8'h40);
        // now 1ns after the last pair's edge: t = 0
        for (int t = 0; t <= n * (1 << d) + 4; t++) begin
          int e;
          e = n - t / (1 << d);
          if (e < 0) e = 0;
          chk("R5 leak", trace, e);
          chk("R8 flag", elig, (e != 0) ? 1 : 0);
          cyc();
        end
        decay = 4'd0;
      end
    end

    // R7: pair on the cycle where a decay step is due
    clear_trace(); decay = 4'd1;
    pulse_pair(8'h01);          // t=0, trace 1
    cyc();                      // t=1, step due at the next edge
    pulse_pair(8'h02);
    chk("R7 inc wins", trace, 2);
    decay = 4'd0;

    // R9: reward releases the stored delta and clears the trace
    clear_trace();
    pulse_pair(8'hA1); pulse_pair(8'hB2);
    reward = 1'b1; cyc(); reward = 1'b0;
    chk("R9 release", rel, 1);
    chk("R9 delta", rel_delta, 8'hB2);
    chk("R9 cleared", trace, 0);
    cyc();
    chk("R9 pulse one cycle", rel, 0);
    chk("R10 delta held", rel_delta, 8'hB2);

    // R10: reward on a zero trace
    reward = 1'b1; cyc(); cyc(); reward = 1'b0;
    chk("R10 no release", rel, 0);
    chk("R10 delta held", rel_delta, 8'hB2);

    // R10: reward after the trace leaked out
    decay = 4'd1; pulse_pair(8'hC3);
    for (int k = 0; k < 3; k++) cyc();
    chk("R5 leaked", trace, 0);
    reward = 1'b1; cyc(); reward = 1'b0;
    chk("R10 late reward", rel, 0);
    decay = 4'd0;

    // R11: reward and pair together
    clear_trace();
    pulse_pair(8'h44);
    reward = 1'b1; pair = 1'b1; delta = 8'h55; cyc();
    reward = 1'b0; pair = 1'b0;
    chk("R11 release", rel, 1);
    chk("R11 old delta", rel_delta, 8'h44);
    chk("R11 cleared", trace, 0);
    pulse_pair(8'h66);
    reward = 1'b1; cyc(); reward = 1'b0;
    chk("R11 latest", rel_delta, 8'h66);

    // R9: reward sweep over delta values
    for (int v = 0; v < 16; v++) begin
      pulse_pair(8'(v * 17));
      reward = 1'b1; cyc(); reward = 1'b0;
      chk("R9 sweep", rel_delta, v * 17);
      chk("R9 sweep clr", trace, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule